// File: doc/BRIEF.md
# Accelerator Tile Peer-Aware DMA Router

This block sits between an accelerator and the on-chip interconnect. It moves the accelerator's input and output data for a fixed number of bursts. Each burst loads a block of words, leaves the accelerator time to compute, and then stores a block of words. The load source and the store target are picked when the run starts, from a small register file loaded over a write-only configuration port.

Loads are read from shared memory, or they are pulled from one or more producer tiles in turn. Stores are written to shared memory, or they are held in the accelerator until a consumer tile asks for them. Traffic between tiles always follows a pull model. Such traffic uses the same request and data ports as memory traffic, and every outgoing word to a tile is the answer to a read request that tile sent first.

Register map (`cfg_addr`): 0 = control, where writing bit 0 as 1 starts a run. 1 = burst count. 2 = words per burst. 3 = mode, with bit 0 set for peer store and bits [6:4] giving the source count. 4 = source list, with source k in bits [4k+3:4k]. 5 = load base address. 6 = store base address. The interconnect identifier of shared memory is the parameter `MEM_ID`, which defaults to 4'hF.

Top module: `p2p_dma_router`

## Requirements
- R1: Register writes go to a shadow copy. Writing 1 to bit 0 of the control register while idle copies every shadow value into the working set, sets `busy` and starts a run. The run then uses only the copied values, and `noc_req_len` equals the words-per-burst value.
- R2: While `busy` is high, every configuration write is ignored, including a second start. The current run keeps its burst count, and a later start with no new writes reuses the earlier shadow values.
- R3: With a source count of 0, every load request has `noc_req_write`=0, destination `MEM_ID` and address load_base + burst_index*words. A request that is not accepted stays valid with the same destination and direction.
- R4: With a source count of 1 to 4, load bursts use the configured sources in rotation: source 0, then 1, and so on up to count-1, then back to source 0. Each run starts again at source 0. These loads use the same request and inbound data ports as memory loads.
- R5: Each burst runs in a fixed order. First comes one load request. Then exactly `words` inbound beats are passed to `acc_ld_valid`/`acc_ld_data`. Only after that is store data accepted. `acc_st_ready` is never high in a cycle that carries a load beat.
- R6: With peer store off, each store burst issues a request with `noc_req_write`=1, destination `MEM_ID` and address store_base + burst_index*words. The accelerator's words then go out on `noc_out_*` with destination `MEM_ID`.
- R7: With peer store on, no store request is issued. `acc_st_ready` and `noc_out_valid` stay low until a pull request is held. The burst's words then go out with `noc_out_dest` equal to the requester's identifier, and the held pull is used up.
- R8: `pull_ready` is high only while busy and while no pull is held. A pull that arrives before its store burst is ready is kept, and it serves the next store burst with no stall.
- R9: `done` is high for exactly one cycle. That cycle follows the last word handshake of the final burst's store, and in it `busy` is already low.
- R10: No word leaves on `noc_out_*` toward a destination other than `MEM_ID` unless a pull request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | DW | Configuration write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| acc_ld_valid | output | 1 | Load word valid toward the accelerator |
| acc_ld_data | output | DW | Load word |
| acc_st_valid | input | 1 | Store word offered by the accelerator |
| acc_st_data | input | DW | Store word |
| acc_st_ready | output | 1 | Store word accepted, low while stalled |
| noc_req_valid | output | 1 | Outbound transfer request valid |
| noc_req_ready | input | 1 | Outbound request accepted |
| noc_req_write | output | 1 | 1 = write to memory, 0 = read |
| noc_req_dest | output | IDW | Request target identifier |
| noc_req_addr | output | AW | Memory address of the burst |
| noc_req_len | output | CW | Words in the burst |
| noc_in_valid | input | 1 | Inbound read data valid |
| noc_in_data | input | DW | Inbound read data |
| noc_out_valid | output | 1 | Outbound data valid |
| noc_out_ready | input | 1 | Outbound data accepted |
| noc_out_dest | output | IDW | Outbound data target identifier |
| noc_out_data | output | DW | Outbound data word |
| pull_valid | input | 1 | Read request from a consumer tile |
| pull_src | input | IDW | Identifier of the requesting tile |
| pull_ready | output | 1 | Pull request accepted |

## Verification
A table of runs tries the load path under four conditions: memory only, a single fixed producer, a rotation over three sources that wraps after the third, and four sources with no wrap. Together these separate a rotation that resets or wraps wrongly from one that works. The store path runs in both modes. In peer mode, a pull that arrives early (before the load) is told apart from a late pull that arrives after a checked stall, so a block that drops held pulls and a block that never stalls each fail a different check. A run with writes during the run, followed by a restart with no new writes, shows whether those writes leaked into either the working copy or the shadow copy.

// File: rtl/p2p_dma_router.sv
module p2p_dma_router #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int IDW = 4,
  parameter int CW = 16,
  parameter logic [IDW-1:0] MEM_ID = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic           busy,
  output logic           done,
  output logic           acc_ld_valid,
  output logic [DW-1:0]  acc_ld_data,
  input  logic           acc_st_valid,
  input  logic [DW-1:0]  acc_st_data,
  output logic           acc_st_ready,
  output logic           noc_req_valid,
  input  logic           noc_req_ready,
  output logic           noc_req_write,
  output logic [IDW-1:0] noc_req_dest,
  output logic [AW-1:0]  noc_req_addr,
  output logic [CW-1:0]  noc_req_len,
  input  logic           noc_in_valid,
  input  logic [DW-1:0]  noc_in_data,
  output logic           noc_out_valid,
  input  logic           noc_out_ready,
  output logic [IDW-1:0] noc_out_dest,
  output logic [DW-1:0]  noc_out_data,
  input  logic           pull_valid,
  input  logic [IDW-1:0] pull_src,
  output logic           pull_ready
);
  localparam int NSRC = 4;
  localparam int SW = NSRC * IDW;

  typedef enum logic [2:0] {S_IDLE, S_LDREQ, S_LDDAT, S_STREQ, S_STDAT} st_t;
  st_t state;

  logic [CW-1:0] sh_nb, sh_len, nb, len, burst, word;
  logic          sh_peer, peer;
  logic [2:0]    sh_cnt, cnt;
  logic [SW-1:0] sh_src, src;
  logic [AW-1:0] sh_lb, sh_sb, ld_addr, st_addr;
  logic [1:0]    rr;
  logic          pend;
  logic [IDW-1:0] pend_src;

  logic wr_ok, start, last_word, last_burst, ld_beat, st_go, st_beat;
  logic [IDW-1:0] ld_dest;
  logic unused_bits;

  assign unused_bits = ^cfg_wdata;
  assign wr_ok      = cfg_we && state == S_IDLE;
  assign start      = wr_ok && cfg_addr == 3'd0 && cfg_wdata[0];
  assign last_word  = word == len - 1'b1;
  assign last_burst = burst == nb - 1'b1;
  assign ld_beat    = state == S_LDDAT && noc_in_valid;
  assign st_go      = state == S_STDAT && (!peer || pend);
  assign st_beat    = st_go && acc_st_valid && noc_out_ready;
  assign ld_dest    = (cnt == 3'd0) ? MEM_ID : src[rr*IDW +: IDW];

  assign busy          = state != S_IDLE;
  assign noc_req_valid = state == S_LDREQ || state == S_STREQ;
  assign noc_req_write = state == S_STREQ;
  assign noc_req_dest  = noc_req_write ? MEM_ID : ld_dest;
  assign noc_req_addr  = noc_req_write ? st_addr : ld_addr;
  assign noc_req_len   = len;
  assign acc_ld_valid  = ld_beat;
  assign acc_ld_data   = noc_in_data;
  assign acc_st_ready  = st_go && noc_out_ready;
  assign noc_out_valid = st_go && acc_st_valid;
  assign noc_out_data  = acc_st_data;
  assign noc_out_dest  = peer ? pend_src : MEM_ID;
  assign pull_ready    = busy && !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_nb <= '0; sh_len <= '0; sh_peer <= 1'b0; sh_cnt <= '0;
      sh_src <= '0; sh_lb <= '0; sh_sb <= '0;
    end else if (wr_ok) begin
      case (cfg_addr)
        3'd1: sh_nb <= cfg_wdata[CW-1:0];
        3'd2: sh_len <= cfg_wdata[CW-1:0];
        3'd3: begin sh_peer <= cfg_wdata[0]; sh_cnt <= cfg_wdata[6:4]; end
        3'd4: sh_src <= cfg_wdata[SW-1:0];
        3'd5: sh_lb <= cfg_wdata[AW-1:0];
        3'd6: sh_sb <= cfg_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      pend_src <= '0;
    end else if (start) begin
      pend <= 1'b0;
    end else if (pull_valid && pull_ready) begin
      pend <= 1'b1;
      pend_src <= pull_src;
    end else if (st_beat && last_word && peer) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done <= 1'b0;
      nb <= '0; len <= '0; peer <= 1'b0; cnt <= '0; src <= '0;
      ld_addr <= '0; st_addr <= '0; burst <= '0; word <= '0; rr <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          nb <= sh_nb; len <= sh_len; peer <= sh_peer; cnt <= sh_cnt;
          src <= sh_src; ld_addr <= sh_lb; st_addr <= sh_sb;
          burst <= '0; word <= '0; rr <= '0;
          state <= S_LDREQ;
        end
        S_LDREQ: if (noc_req_ready) state <= S_LDDAT;
        S_LDDAT: if (ld_beat) begin
          if (last_word) begin
            word <= '0;
            ld_addr <= ld_addr + {{(AW-CW){1'b0}}, len};
            if (cnt > 3'd1) rr <= ({1'b0, rr} == cnt - 3'd1) ? 2'd0 : rr + 2'd1;
            state <= peer ? S_STDAT : S_STREQ;
          end else begin
            word <= word + 1'b1;
          end
        end
        S_STREQ: if (noc_req_ready) state <= S_STDAT;
        S_STDAT: if (st_beat) begin
          if (last_word) begin
            word <= '0;
            st_addr <= st_addr + {{(AW-CW){1'b0}}, len};
            if (last_burst) begin
              state <= S_IDLE;
              done <= 1'b1;
            end else begin
              burst <= burst + 1'b1;
              state <= S_LDREQ;
            end
          end else begin
            word <= word + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/p2p_dma_router_chk.sv
module p2p_dma_router_chk #(
  parameter int IDW = 4,
  parameter logic [IDW-1:0] MEM_ID = '1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           acc_ld_valid,
  input logic           acc_st_ready,
  input logic           noc_req_valid,
  input logic           noc_req_ready,
  input logic           noc_req_write,
  input logic [IDW-1:0] noc_req_dest,
  input logic           noc_out_valid,
  input logic [IDW-1:0] noc_out_dest,
  input logic           pull_ready,
  input logic           peer,
  input logic           pend
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    noc_req_valid && !noc_req_ready |=> noc_req_valid && $stable(noc_req_dest) && $stable(noc_req_write)); // R3
  AST_LOAD_STORE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ld_valid |-> !acc_st_ready); // R5
  AST_PEER_WAITS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    peer && busy && !pend |-> !acc_st_ready && !noc_out_valid); // R7
  AST_PULL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pull_ready); // R8
  AST_PULL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pend && !noc_out_valid |=> pend); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    noc_out_valid && noc_out_dest != MEM_ID |-> pend); // R10
endmodule

bind p2p_dma_router p2p_dma_router_chk #(.IDW(IDW), .MEM_ID(MEM_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .acc_ld_valid(acc_ld_valid), .acc_st_ready(acc_st_ready),
  .noc_req_valid(noc_req_valid), .noc_req_ready(noc_req_ready),
  .noc_req_write(noc_req_write), .noc_req_dest(noc_req_dest),
  .noc_out_valid(noc_out_valid), .noc_out_dest(noc_out_dest),
  .pull_ready(pull_ready), .peer(peer), .pend(pend)
);

// File: tb/tb_p2p_dma_router.sv
module tb_p2p_dma_router;
  localparam logic [3:0]  MEM = 4'hF;
  localparam logic [31:0] LB = 32'h0000_1000;
  localparam logic [31:0] SB = 32'h0000_8000;
  // {pad4, exp dests[43:28], srcs[27:12], cnt[11:9], peer[8], len[7:4], nb[3:0]}
  localparam logic [47:0] VEC [6] = '{
    {4'h0, 16'hFFFF, 16'h0000, 3'd0, 1'b0, 4'd3, 4'd2},
    {4'h0, 16'h3333, 16'h0003, 3'd1, 1'b0, 4'd2, 4'd4},
    {4'h0, 16'h7927, 16'h0927, 3'd3, 1'b0, 4'd1, 4'd4},
    {4'h0, 16'hFFFF, 16'h0000, 3'd0, 1'b1, 4'd4, 4'd3},
    {4'h0, 16'h6A6A, 16'h006A, 3'd2, 1'b1, 4'd2, 4'd4},
    {4'h0, 16'h4321, 16'h4321, 3'd4, 1'b0, 4'd3, 4'd4}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic busy, done, acc_ld_valid, acc_st_ready, noc_req_valid, noc_req_write;
  logic [31:0] acc_ld_data, noc_req_addr, noc_out_data;
  logic [15:0] noc_req_len;
  logic [3:0] noc_req_dest, noc_out_dest;
  logic noc_out_valid, pull_ready;
  logic acc_st_valid = 0; logic [31:0] acc_st_data = 0;
  logic noc_req_ready = 0, noc_in_valid = 0, noc_out_ready = 0, pull_valid = 0;
  logic [31:0] noc_in_data = 0; logic [3:0] pull_src = 0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  p2p_dma_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .busy(busy), .done(done), .acc_ld_valid(acc_ld_valid), .acc_ld_data(acc_ld_data),
    .acc_st_valid(acc_st_valid), .acc_st_data(acc_st_data), .acc_st_ready(acc_st_ready),
    .noc_req_valid(noc_req_valid), .noc_req_ready(noc_req_ready), .noc_req_write(noc_req_write),
    .noc_req_dest(noc_req_dest), .noc_req_addr(noc_req_addr), .noc_req_len(noc_req_len),
    .noc_in_valid(noc_in_valid), .noc_in_data(noc_in_data), .noc_out_valid(noc_out_valid),
    .noc_out_ready(noc_out_ready), .noc_out_dest(noc_out_dest), .noc_out_data(noc_out_data),
    .pull_valid(pull_valid), .pull_src(pull_src), .pull_ready(pull_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wait_req(input string req);
    int n = 0;
    #1;
    while (!noc_req_valid && n < 50) begin @(negedge clk); #1; n++; end
    if (!noc_req_valid) chk(0, req, 0, 1);
  endtask

  task automatic do_run(input int nb, input int len, input bit peer, input int cnt,
                        input logic [15:0] srcs, input logic [15:0] exp, input bit mid, input bit docfg);
    if (docfg) begin
      cfg_wr(3'd1, nb); cfg_wr(3'd2, len); cfg_wr(3'd3, (cnt << 4) | peer);
      cfg_wr(3'd4, {16'h0, srcs}); cfg_wr(3'd5, LB); cfg_wr(3'd6, SB);
    end
    cfg_wr(3'd0, 1);
    for (int b = 0; b < nb; b++) begin
      if (peer && b % 2 == 0) begin
        pull_valid = 1; pull_src = 4'(5 + b);
        #1 chk(pull_ready == 1, "R8 early pull accepted", pull_ready, 1);
        @(negedge clk); pull_valid = 0;
      end
      wait_req("R5 load request");
      chk(noc_req_write == 0, "R3 load is read", noc_req_write, 0);
      chk(noc_req_dest == exp[b*4 +: 4], (cnt == 0) ? "R3 load dest memory" : "R4 rotated source",
          noc_req_dest, exp[b*4 +: 4]);
      chk(noc_req_addr == LB + b*len, "R3 load addr", noc_req_addr, LB + b*len);
      chk(noc_req_len == len, "R1 latched length", noc_req_len, len);
      noc_req_ready = 1; @(negedge clk); noc_req_ready = 0;
      for (int w = 0; w < len; w++) begin
        noc_in_valid = 1; noc_in_data = 32'h1000_0000 + b*256 + w;
        cfg_we = mid && b == 0 && w < 2; cfg_addr = (w == 0) ? 3'd1 : 3'd0;
        cfg_wdata = (w == 0) ? 32'd7 : 32'd1;
        #1 chk(acc_ld_valid && acc_ld_data == noc_in_data, "R5 load beat", acc_ld_data, noc_in_data);
        chk(!acc_st_ready, "R5 no store during load", acc_st_ready, 0);
        @(negedge clk);
      end
      noc_in_valid = 0; cfg_we = 0;
      if (!peer) begin
        wait_req("R6 store request");
        chk(noc_req_write == 1 && noc_req_dest == MEM, "R6 store to memory", {noc_req_write, noc_req_dest}, {1'b1, MEM});
        chk(noc_req_addr == SB + b*len, "R6 store addr", noc_req_addr, SB + b*len);
        noc_req_ready = 1; @(negedge clk); noc_req_ready = 0;
      end else if (b % 2 == 1) begin
        acc_st_valid = 1; noc_out_ready = 1;
        for (int k = 0; k < 3; k++) begin
          #1 chk(!acc_st_ready && !noc_out_valid, "R7 stall until pull", {acc_st_ready, noc_out_valid}, 0);
          @(negedge clk);
        end
        pull_valid = 1; pull_src = 4'(5 + b);
        #1 chk(pull_ready == 1, "R8 pull accepted", pull_ready, 1);
        @(negedge clk); pull_valid = 0;
      end
      for (int w = 0; w < len; w++) begin
        acc_st_valid = 1; noc_out_ready = 1; acc_st_data = 32'h5000_0000 + b*256 + w;
        #1 chk(acc_st_ready && noc_out_valid && noc_out_data == acc_st_data,
               peer ? "R7 peer store word" : "R6 memory store word", noc_out_data, acc_st_data);
        chk(noc_out_dest == (peer ? 4'(5 + b) : MEM), peer ? "R7 requester dest" : "R6 memory dest",
            noc_out_dest, peer ? 4'(5 + b) : MEM);
        @(negedge clk);
      end
      acc_st_valid = 0; noc_out_ready = 0;
      #1;
      if (b == nb - 1) chk(done && !busy, "R9 done after final store", {done, busy}, 2'b10);
      else chk(!done && busy, "R2 R9 run continues", {done, busy}, 2'b01);
    end
    @(negedge clk);
    #1 chk(!done, "R9 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(!busy && !done && !noc_req_valid && !noc_out_valid && !acc_st_ready,
           "reset outputs idle", {busy, done, noc_req_valid, noc_out_valid, acc_st_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    #1 chk(!pull_ready && !busy, "R8 no pull accepted while idle", {pull_ready, busy}, 0);
    for (int i = 0; i < 6; i++)
      do_run(VEC[i][3:0], VEC[i][7:4], VEC[i][8], VEC[i][11:9], VEC[i][27:12], VEC[i][43:28], 0, 1);
    // R2: writes during a run are dropped, then a restart reuses the old shadow set
    do_run(2, 2, 0, 0, 16'h0, 16'hFFFF, 1, 1);
    do_run(2, 2, 0, 0, 16'h0, 16'hFFFF, 0, 0);
    // R4: rotation starts again at source 0 on a new run
    do_run(2, 1, 0, 3, 16'h0927, 16'hFF27, 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule